// File: doc/BRIEF.md
# Arbitrated AXI Burst DMA Channel

This block is a single DMA channel. It carries fixed-length bursts between two stream-side FIFOs and memory through an AXI4 master port. The write path drains a write FIFO into memory. The read path fills a read FIFO from memory. The FIFOs themselves sit outside the block; the channel sees only their fill levels, a first-word-fall-through data port on the write side, and pop, push and flush strobes.

The channel never starts a burst on its own. In each direction it raises a request toward an external arbiter and waits for a grant. Once granted, it presents the address, moves exactly one burst, and marks the two ends of the transfer with a start pulse and an end pulse. The arbiter reads the end pulse as the close of the round. Successive bursts walk through a ring of equal-sized frame buffers. The number of buffers in the ring comes from an input, and the buffer currently in use is reported on an output.

A frame-sync pulse flushes the write FIFO for a fixed number of cycles. This drops any stale data left from the previous frame. It also points the write address back at the start of the current buffer. If the pulse arrives while a write burst is in flight, the flush is held off until that burst has ended. No new write request appears until the flush is over.

Top module: `axi_burst_dma_chan`

## Requirements
- R1: While reset is held and right after it is released, `wr_req`, `m_awvalid`, `m_wvalid`, `m_arvalid`, `m_rready`, `wf_flush` and `bresp_err` are 0, and both buffer indices are 0.
- R2: With no write burst pending or active, no flush running or pending, and no frame sync present, `wr_req` is 1 exactly when `wf_level` is at least BURST_LEN.
- R3: With no read burst pending or active, `rd_req` is 1 exactly when `rf_level` is at most RD_LOW_MARK.
- R4: A grant is taken only on a cycle where the matching request is 1. The address valid rises on the next cycle and holds, with a stable address, until its ready is 1. The start pulse is 1 exactly on the address handshake cycle. The burst uses length code BURST_LEN-1, a size code of log2 of the bytes per beat, burst type INCR (2'b01) and all strobe bits set.
- R5: After the write start, `m_wvalid` stays 1 until BURST_LEN beats have been accepted. `wf_pop` is 1 exactly on the accepted beats, and `m_wdata` is `wf_data`. `m_wlast` and `wr_end` are 1 exactly on the last accepted beat. `m_wvalid` is 0 on the cycle after.
- R6: After the read start, `m_rready` stays 1 until a beat with `m_rlast` is accepted. `rf_push` is 1 exactly on the accepted beats, and `rf_data` is `m_rdata`. `rd_end` is 1 only on the accepted last beat. `m_rready` is 0 on the cycle after.
- R7: While a burst in one direction is pending or active, that direction's request is 0, so each grant covers one burst from start to end.
- R8: A burst address is BASE_ADDR + index*FRAME_BYTES + offset. Each end pulse adds BURST_LEN*DATA_W/8 to the offset. When the offset reaches FRAME_BYTES, it returns to 0 and the index moves to the next buffer, going back to 0 after index `num_bufs`-1. A `num_bufs` of 0 acts as 1.
- R9: A frame sync seen while the write path is idle keeps `wr_req` at 0 on that cycle. `wf_flush` is then 1 for exactly FLUSH_CYCLES cycles from the next cycle on, with `wr_req` held at 0. The next write burst starts at offset 0 of the current buffer.
- R10: A frame sync seen during a write burst leaves `wf_flush` at 0 until that burst ends. The flush then begins one cycle after the idle cycle that follows the end, with the same length and restart as in R9.
- R11: `m_bready` is always 1. `bresp_err` becomes 1 after a response with `m_bvalid` high and `m_bresp` of 2'b10 or 2'b11, and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| num_bufs | input | BUF_W | Number of frame buffers in the ring (0 acts as 1) |
| frame_sync | input | 1 | Frame-start pulse that flushes the write path |
| wf_level | input | LVL_W | Words readable from the write FIFO |
| wf_data | input | DATA_W | Head word of the write FIFO |
| wf_pop | output | 1 | Pop the write FIFO head |
| wf_flush | output | 1 | Flush the write FIFO |
| rf_level | input | LVL_W | Words held in the read FIFO |
| rf_push | output | 1 | Push a word into the read FIFO |
| rf_data | output | DATA_W | Word pushed into the read FIFO |
| wr_req | output | 1 | Write burst request to the arbiter |
| wr_grant | input | 1 | Write grant from the arbiter |
| wr_start | output | 1 | Write burst start pulse |
| wr_end | output | 1 | Write burst end pulse |
| wr_buf_idx | output | BUF_W | Buffer being written |
| rd_req | output | 1 | Read burst request to the arbiter |
| rd_grant | input | 1 | Read grant from the arbiter |
| rd_start | output | 1 | Read burst start pulse |
| rd_end | output | 1 | Read burst end pulse |
| rd_buf_idx | output | BUF_W | Buffer being read |
| bresp_err | output | 1 | Sticky write-response error |
| m_awaddr | output | ADDR_W | Write address |
| m_awlen | output | 8 | Write burst length code |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write strobes |
| m_wlast | output | 1 | Last write beat |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | ADDR_W | Read address |
| m_arlen | output | 8 | Read burst length code |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rlast | input | 1 | Last read beat |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
The bench builds the channel with 32-bit data, 4-beat bursts, 64-byte frames (four bursts per frame), a 3-bit buffer index, a low mark of 2, a 3-cycle flush and a non-zero base address. Because the frames are this short, every ring size from 0 through 4 can be swept past two full wraps in both directions. Expected addresses and indices come from plain offset and index arithmetic. The same small configuration makes the request thresholds reachable at their exact boundary levels. It also lets the bench place a frame sync both in the idle gap and in the middle of a stalled write burst.

// File: rtl/axi_dma_pkg.sv
`timescale 1ns/1ps
package axi_dma_pkg;
  localparam logic [1:0] AXI_BURST_INCR = 2'b01;

  function automatic logic [2:0] axi_size_code(input int bytes_per_beat);
    return 3'($clog2(bytes_per_beat));
  endfunction
endpackage

// File: rtl/dma_addr_ring.sv
`timescale 1ns/1ps
module dma_addr_ring #(
  parameter int          ADDR_W      = 32,
  parameter int          BUF_W       = 3,
  parameter logic [63:0] BASE_ADDR   = 64'h0,
  parameter int          FRAME_BYTES = 4096,
  parameter int          BURST_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUF_W-1:0]  num_bufs,
  input  logic              step,
  input  logic              restart,
  output logic [ADDR_W-1:0] addr,
  output logic [BUF_W-1:0]  buf_idx
);
  localparam int OFS_W = $clog2(FRAME_BYTES + 1);
  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(FRAME_BYTES - BURST_BYTES);

  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic [BUF_W-1:0] idx_q, idx_d;
  logic [BUF_W:0]   idx_plus;
  logic             at_frame_end, at_last_buf;

  always_comb begin
    idx_plus     = {1'b0, idx_q} + {{BUF_W{1'b0}}, 1'b1};
    at_frame_end = (ofs_q == LAST_OFS);
    at_last_buf  = (idx_plus >= {1'b0, num_bufs});
    ofs_d = ofs_q;
    idx_d = idx_q;
    if (restart) begin
      ofs_d = '0;
    end else if (step) begin
      if (at_frame_end) begin
        ofs_d = '0;
        idx_d = at_last_buf ? '0 : idx_plus[BUF_W-1:0];
      end else begin
        ofs_d = ofs_q + OFS_W'(BURST_BYTES);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
      idx_q <= '0;
    end else if (restart || step) begin
      ofs_q <= ofs_d;
      idx_q <= idx_d;
    end
  end

  assign addr    = ADDR_W'(BASE_ADDR) + (ADDR_W'(idx_q) * ADDR_W'(FRAME_BYTES)) + ADDR_W'(ofs_q);
  assign buf_idx = idx_q;

  // R8: a frame wrap moves to the next buffer or back to zero
  a_r8_wrap_index: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && at_frame_end) |=> (idx_q == '0 || idx_q == $past(idx_q) + BUF_W'(1)));
  // R8: a step inside a frame keeps the buffer index
  a_r8_step_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && !at_frame_end) |=> $stable(idx_q));
endmodule

// File: rtl/dma_frame_flush.sv
`timescale 1ns/1ps
module dma_frame_flush #(
  parameter int FLUSH_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_sync,
  input  logic busy,
  output logic flush,
  output logic restart,
  output logic inhibit
);
  localparam int FL_W = $clog2(FLUSH_CYCLES + 1);

  logic [FL_W-1:0] cnt_q, cnt_d;
  logic            pend_q, pend_d;
  logic            start;

  always_comb begin
    start  = (frame_sync || pend_q) && !busy;
    pend_d = pend_q;
    if (start)                   pend_d = 1'b0;
    else if (frame_sync && busy) pend_d = 1'b1;
    cnt_d = cnt_q;
    if (start)                 cnt_d = FL_W'(FLUSH_CYCLES);
    else if (cnt_q != '0)      cnt_d = cnt_q - FL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign flush   = (cnt_q != '0);
  assign restart = start;
  assign inhibit = pend_q || flush || frame_sync;

  // R9: the write FIFO is never flushed while a write burst is open
  a_r9_flush_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !busy);
  // R10: a sync during a burst does not flush on the following cycle
  a_r10_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && busy && !flush) |=> !flush);
endmodule

// File: rtl/dma_wr_mover.sv
`timescale 1ns/1ps
module dma_wr_mover #(
  parameter int DATA_W    = 64,
  parameter int BURST_LEN = 16,
  parameter int LVL_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  level,
  input  logic              inhibit,
  input  logic              grant,
  input  logic              awready,
  input  logic              wready,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              req,
  output logic              awvalid,
  output logic              wvalid,
  output logic              wlast,
  output logic [DATA_W-1:0] wdata,
  output logic              pop,
  output logic              burst_start,
  output logic              burst_end,
  output logic              busy
);
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  logic              pend_q, pend_d, act_q, act_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              fire;

  always_comb begin
    busy        = pend_q || act_q;
    req         = !busy && !inhibit && (level >= LVL_W'(BURST_LEN));
    awvalid     = pend_q;
    burst_start = pend_q && awready;
    wvalid      = act_q;
    fire        = act_q && wready;
    wlast       = act_q && (beat_q == LAST_BEAT);
    burst_end   = fire && (beat_q == LAST_BEAT);
    pop         = fire;
    wdata       = fifo_data;

    pend_d = pend_q;
    if (req && grant)     pend_d = 1'b1;
    else if (burst_start) pend_d = 1'b0;

    act_d = act_q;
    if (burst_end && act_q)          act_d = 1'b0;
    else if (burst_start && !act_q)  act_d = 1'b1;

    beat_d = beat_q;
    if (burst_end) beat_d = '0;
    else if (fire) beat_d = beat_q + BEAT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      beat_q <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      beat_q <= beat_d;
    end
  end

  // R4: address valid holds until accepted
  a_r4_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> awvalid);
  // R4: the data phase follows the address handshake
  a_r4_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> wvalid);
  // R5: the path is quiet after the last beat
  a_r5_end_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> (!wvalid && !awvalid));
endmodule

// File: rtl/dma_rd_mover.sv
`timescale 1ns/1ps
module dma_rd_mover #(
  parameter int DATA_W      = 64,
  parameter int LVL_W       = 12,
  parameter int RD_LOW_MARK = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  level,
  input  logic              grant,
  input  logic              arready,
  input  logic              rvalid,
  input  logic              rlast,
  input  logic [DATA_W-1:0] rdata,
  output logic              req,
  output logic              arvalid,
  output logic              rready,
  output logic              burst_start,
  output logic              burst_end,
  output logic              push,
  output logic [DATA_W-1:0] push_data
);
  logic pend_q, pend_d, act_q, act_d;
  logic fire;

  always_comb begin
    req         = !pend_q && !act_q && (level <= LVL_W'(RD_LOW_MARK));
    arvalid     = pend_q;
    burst_start = pend_q && arready;
    rready      = act_q;
    fire        = act_q && rvalid;
    burst_end   = fire && rlast;
    push        = fire;
    push_data   = rdata;

    pend_d = pend_q;
    if (req && grant)     pend_d = 1'b1;
    else if (burst_start) pend_d = 1'b0;

    act_d = act_q;
    if (burst_end && act_q)         act_d = 1'b0;
    else if (burst_start && !act_q) act_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  // R4: read address valid holds until accepted
  a_r4_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && !arready) |=> arvalid);
  // R6: ready drops after the last beat
  a_r6_end_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> !rready);
  // R7: no read request while a read burst is open
  a_r7_rd_one_round: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid || rready) |-> !req);
endmodule

// File: rtl/axi_burst_dma_chan.sv
`timescale 1ns/1ps
module axi_burst_dma_chan
  import axi_dma_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter int          DATA_W       = 64,
  parameter int          BURST_LEN    = 16,
  parameter int          LVL_W        = 12,
  parameter int          BUF_W        = 3,
  parameter int          FRAME_BYTES  = 4096,
  parameter int          RD_LOW_MARK  = 16,
  parameter int          FLUSH_CYCLES = 8,
  parameter logic [63:0] BASE_ADDR    = 64'h0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BUF_W-1:0]    num_bufs,
  input  logic                frame_sync,
  input  logic [LVL_W-1:0]    wf_level,
  input  logic [DATA_W-1:0]   wf_data,
  output logic                wf_pop,
  output logic                wf_flush,
  input  logic [LVL_W-1:0]    rf_level,
  output logic                rf_push,
  output logic [DATA_W-1:0]   rf_data,
  output logic                wr_req,
  input  logic                wr_grant,
  output logic                wr_start,
  output logic                wr_end,
  output logic [BUF_W-1:0]    wr_buf_idx,
  output logic                rd_req,
  input  logic                rd_grant,
  output logic                rd_start,
  output logic                rd_end,
  output logic [BUF_W-1:0]    rd_buf_idx,
  output logic                bresp_err,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [7:0]          m_arlen,
  output logic [2:0]          m_arsize,
  output logic [1:0]          m_arburst,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic                m_rlast,
  input  logic                m_rvalid,
  output logic                m_rready
);
  localparam int BEAT_BYTES  = DATA_W / 8;
  localparam int BURST_BYTES = BURST_LEN * BEAT_BYTES;
  localparam logic [7:0] LEN_CODE  = 8'(BURST_LEN - 1);
  localparam logic [2:0] SIZE_CODE = axi_size_code(BEAT_BYTES);

  logic wr_busy, wr_inhibit, wr_restart;
  logic err_q, err_d;

  dma_frame_flush #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_flush (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .busy(wr_busy),
    .flush(wf_flush), .restart(wr_restart), .inhibit(wr_inhibit)
  );

  dma_wr_mover #(.DATA_W(DATA_W), .BURST_LEN(BURST_LEN), .LVL_W(LVL_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .level(wf_level), .inhibit(wr_inhibit),
    .grant(wr_grant), .awready(m_awready), .wready(m_wready), .fifo_data(wf_data),
    .req(wr_req), .awvalid(m_awvalid), .wvalid(m_wvalid), .wlast(m_wlast),
    .wdata(m_wdata), .pop(wf_pop), .burst_start(wr_start), .burst_end(wr_end),
    .busy(wr_busy)
  );

  dma_rd_mover #(.DATA_W(DATA_W), .LVL_W(LVL_W), .RD_LOW_MARK(RD_LOW_MARK)) u_rd (
    .clk(clk), .rst_n(rst_n), .level(rf_level), .grant(rd_grant),
    .arready(m_arready), .rvalid(m_rvalid), .rlast(m_rlast), .rdata(m_rdata),
    .req(rd_req), .arvalid(m_arvalid), .rready(m_rready), .burst_start(rd_start),
    .burst_end(rd_end), .push(rf_push), .push_data(rf_data)
  );

  dma_addr_ring #(.ADDR_W(ADDR_W), .BUF_W(BUF_W), .BASE_ADDR(BASE_ADDR),
                  .FRAME_BYTES(FRAME_BYTES), .BURST_BYTES(BURST_BYTES)) u_wr_ring (
    .clk(clk), .rst_n(rst_n), .num_bufs(num_bufs), .step(wr_end),
    .restart(wr_restart), .addr(m_awaddr), .buf_idx(wr_buf_idx)
  );

  dma_addr_ring #(.ADDR_W(ADDR_W), .BUF_W(BUF_W), .BASE_ADDR(BASE_ADDR),
                  .FRAME_BYTES(FRAME_BYTES), .BURST_BYTES(BURST_BYTES)) u_rd_ring (
    .clk(clk), .rst_n(rst_n), .num_bufs(num_bufs), .step(rd_end),
    .restart(1'b0), .addr(m_araddr), .buf_idx(rd_buf_idx)
  );

  assign m_awlen   = LEN_CODE;
  assign m_awsize  = SIZE_CODE;
  assign m_awburst = AXI_BURST_INCR;
  assign m_arlen   = LEN_CODE;
  assign m_arsize  = SIZE_CODE;
  assign m_arburst = AXI_BURST_INCR;
  assign m_wstrb   = '1;
  assign m_bready  = 1'b1;

  always_comb begin
    err_d = err_q;
    if (m_bvalid && (m_bresp == 2'b10 || m_bresp == 2'b11)) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign bresp_err = err_q;

  // R11: the error flag is sticky
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bresp_err |=> bresp_err);
  // R4: addresses hold while waiting for the handshake
  a_r4_awaddr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && !m_awready) |=> $stable(m_awaddr));
  a_r4_araddr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && !m_arready) |=> $stable(m_araddr));
  // R7: no write request while a write burst is open
  a_r7_wr_one_round: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid || m_wvalid) |-> !wr_req);
endmodule

// File: tb/axi_burst_dma_chan_test.sv
`timescale 1ns/1ps
module axi_burst_dma_chan_test;
  localparam int BL = 4;
  localparam int FB = 64;
  localparam int BB = 16;
  localparam int LOWM = 2;
  localparam int FLC = 3;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, frame_sync, wr_grant, rd_grant;
  logic [2:0] num_bufs;
  logic [5:0] wf_level, rf_level;
  logic [31:0] wf_data, m_rdata;
  logic m_awready, m_wready, m_bvalid, m_arready, m_rlast, m_rvalid;
  logic [1:0] m_bresp;
  logic wf_pop, wf_flush, rf_push, wr_req, wr_start, wr_end, rd_req, rd_start, rd_end, bresp_err;
  logic [31:0] rf_data, m_awaddr, m_wdata, m_araddr;
  logic [2:0] wr_buf_idx, rd_buf_idx, m_awsize, m_arsize;
  logic [7:0] m_awlen, m_arlen;
  logic [1:0] m_awburst, m_arburst;
  logic [3:0] m_wstrb;
  logic m_awvalid, m_wlast, m_wvalid, m_bready, m_arvalid, m_rready;

  axi_burst_dma_chan #(.ADDR_W(32), .DATA_W(32), .BURST_LEN(BL), .LVL_W(6), .BUF_W(3),
    .FRAME_BYTES(FB), .RD_LOW_MARK(LOWM), .FLUSH_CYCLES(FLC), .BASE_ADDR(64'h0001_0000)) uut (
    .clk(clk), .rst_n(rst_n), .num_bufs(num_bufs), .frame_sync(frame_sync),
    .wf_level(wf_level), .wf_data(wf_data), .wf_pop(wf_pop), .wf_flush(wf_flush),
    .rf_level(rf_level), .rf_push(rf_push), .rf_data(rf_data),
    .wr_req(wr_req), .wr_grant(wr_grant), .wr_start(wr_start), .wr_end(wr_end), .wr_buf_idx(wr_buf_idx),
    .rd_req(rd_req), .rd_grant(rd_grant), .rd_start(rd_start), .rd_end(rd_end), .rd_buf_idx(rd_buf_idx),
    .bresp_err(bresp_err),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
    .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
    .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rlast(m_rlast), .m_rvalid(m_rvalid), .m_rready(m_rready)
  );

  int tests = 0;
  int fails = 0;
  int eff = 1;
  int w_idx, w_ofs, r_idx, r_ofs;
  int wctr = 0;
  int rctr = 0;
  int cyc = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input int idx, input int ofs);
    return BASE + 32'(idx * FB) + 32'(ofs);
  endfunction

  task automatic advance(inout int idx, inout int ofs);
    ofs = ofs + BB;
    if (ofs == FB) begin
      ofs = 0;
      idx = (idx + 1 >= eff) ? 0 : idx + 1;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic do_reset(input int nb);
    rst_n = 1'b0; num_bufs = 3'(nb); frame_sync = 0; wr_grant = 0; rd_grant = 0;
    wf_level = 0; rf_level = 6'd20; wf_data = 0; m_rdata = 0;
    m_awready = 0; m_wready = 0; m_bvalid = 0; m_bresp = 0; m_arready = 0; m_rlast = 0; m_rvalid = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 awvalid in reset", m_awvalid, 0);
    chk("R1 flush in reset", wf_flush, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 wr_req", wr_req, 0);
    chk("R1 wvalid", m_wvalid, 0);
    chk("R1 arvalid", m_arvalid, 0);
    chk("R1 rready", m_rready, 0);
    chk("R1 wr_buf_idx", wr_buf_idx, 0);
    chk("R1 rd_buf_idx", rd_buf_idx, 0);
    chk("R1 bresp_err", bresp_err, 0);
    eff = (nb == 0) ? 1 : nb;
    w_idx = 0; w_ofs = 0; r_idx = 0; r_ofs = 0;
  endtask

  task automatic do_wr(input bit sync_mid, input logic [1:0] resp);
    logic [31:0] ea;
    ea = exp_addr(w_idx, w_ofs);
    @(negedge clk);
    wf_level = 6'(BL - 1); wf_data = 32'hD000_0000 + 32'(wctr);
    #1 chk("R2 below burst length", wr_req, 0);
    wf_level = 6'(BL);
    #1 chk("R2 at burst length", wr_req, 1);
    wr_grant = 1;
    @(negedge clk);
    wr_grant = 0;
    #1;
    chk("R4 awvalid", m_awvalid, 1);
    chk("R8 awaddr", m_awaddr, ea);
    chk("R8 wr_buf_idx", wr_buf_idx, 3'(w_idx));
    chk("R4 awlen", m_awlen, BL - 1);
    chk("R4 awsize", m_awsize, 2);
    chk("R4 awburst", m_awburst, 1);
    chk("R4 wstrb", m_wstrb, 4'hF);
    chk("R7 wr_req while pending", wr_req, 0);
    chk("R4 no start while stalled", wr_start, 0);
    @(negedge clk);
    #1 chk("R4 awvalid held", m_awvalid, 1);
    chk("R4 awaddr held", m_awaddr, ea);
    m_awready = 1;
    #1 chk("R4 start on handshake", wr_start, 1);
    @(negedge clk);
    m_awready = 0;
    #1 chk("R5 wvalid after start", m_wvalid, 1);
    chk("R7 wr_req while active", wr_req, 0);
    for (int b = 0; b < BL; b++) begin
      if (b == 2) begin
        m_wready = 0;
        if (sync_mid) frame_sync = 1;
        #1 chk("R5 wvalid held under stall", m_wvalid, 1);
        chk("R5 no pop under stall", wf_pop, 0);
        @(negedge clk);
        frame_sync = 0;
      end
      m_wready = 1;
      #1;
      chk("R5 pop on beat", wf_pop, 1);
      chk("R5 wdata", m_wdata, wf_data);
      chk("R5 wlast", m_wlast, (b == BL - 1));
      chk("R5 wr_end", wr_end, (b == BL - 1));
      if (sync_mid) chk("R10 no flush during burst", wf_flush, 0);
      @(negedge clk);
      wctr++;
      wf_level = wf_level - 1;
      wf_data = 32'hD000_0000 + 32'(wctr);
    end
    m_wready = 0;
    #1 chk("R5 wvalid low after end", m_wvalid, 0);
    advance(w_idx, w_ofs);
    m_bvalid = 1; m_bresp = resp;
    #1 chk("R11 bready", m_bready, 1);
    if (sync_mid) begin
      wf_level = 6'(BL);
      chk("R10 flush not yet", wf_flush, 0);
      chk("R10 wr_req held off", wr_req, 0);
      @(negedge clk);
      m_bvalid = 0;
      for (int k = 0; k < FLC; k++) begin
        #1 chk("R10 flush active", wf_flush, 1);
        chk("R10 wr_req during flush", wr_req, 0);
        @(negedge clk);
      end
      #1 chk("R10 flush done", wf_flush, 0);
      chk("R10 wr_req after flush", wr_req, 1);
      w_ofs = 0;
    end else begin
      @(negedge clk);
      m_bvalid = 0;
    end
  endtask

  task automatic do_sync_idle();
    @(negedge clk);
    wf_level = 6'(BL); frame_sync = 1;
    #1 chk("R9 wr_req with sync", wr_req, 0);
    chk("R9 no flush yet", wf_flush, 0);
    @(negedge clk);
    frame_sync = 0;
    for (int k = 0; k < FLC; k++) begin
      #1 chk("R9 flush active", wf_flush, 1);
      chk("R9 wr_req during flush", wr_req, 0);
      @(negedge clk);
    end
    #1 chk("R9 flush length", wf_flush, 0);
    chk("R9 wr_req after flush", wr_req, 1);
    w_ofs = 0;
  endtask

  task automatic do_rd();
    logic [31:0] ea;
    ea = exp_addr(r_idx, r_ofs);
    @(negedge clk);
    rf_level = 6'(LOWM + 1);
    #1 chk("R3 above low mark", rd_req, 0);
    rf_level = 6'(LOWM);
    #1 chk("R3 at low mark", rd_req, 1);
    rd_grant = 1;
    @(negedge clk);
    rd_grant = 0;
    #1;
    chk("R4 arvalid", m_arvalid, 1);
    chk("R8 araddr", m_araddr, ea);
    chk("R8 rd_buf_idx", rd_buf_idx, 3'(r_idx));
    chk("R4 arlen", m_arlen, BL - 1);
    chk("R4 arsize", m_arsize, 2);
    chk("R4 arburst", m_arburst, 1);
    chk("R7 rd_req while pending", rd_req, 0);
    m_arready = 1;
    #1 chk("R4 rd_start on handshake", rd_start, 1);
    @(negedge clk);
    m_arready = 0;
    #1 chk("R6 rready after start", m_rready, 1);
    chk("R7 rd_req while active", rd_req, 0);
    for (int b = 0; b < BL; b++) begin
      if (b == 1) begin
        m_rvalid = 0;
        #1 chk("R6 no push without valid", rf_push, 0);
        chk("R6 rready held", m_rready, 1);
        @(negedge clk);
      end
      m_rvalid = 1; m_rlast = (b == BL - 1); m_rdata = 32'hC000_0000 + 32'(rctr);
      #1;
      chk("R6 push on beat", rf_push, 1);
      chk("R6 push data", rf_data, m_rdata);
      chk("R6 rd_end", rd_end, (b == BL - 1));
      @(negedge clk);
      rctr++;
    end
    m_rvalid = 0; m_rlast = 0; rf_level = 6'd20;
    #1 chk("R6 rready low after end", m_rready, 0);
    advance(r_idx, r_ofs);
  endtask

  initial begin
    for (int nb = 0; nb <= 4; nb++) begin
      do_reset(nb);
      for (int i = 0; i < 4 * eff * 2 + 1; i++) do_wr(1'b0, 2'b00);
      for (int i = 0; i < 4 * eff * 2 + 1; i++) do_rd();
    end
    do_reset(3);
    do_wr(1'b0, 2'b00);
    do_wr(1'b0, 2'b00);
    do_sync_idle();
    do_wr(1'b0, 2'b00);
    do_wr(1'b1, 2'b00);
    do_wr(1'b0, 2'b00);
    do_wr(1'b0, 2'b01);
    #1 chk("R11 exokay is not an error", bresp_err, 0);
    do_wr(1'b0, 2'b10);
    #1 chk("R11 slverr sets flag", bresp_err, 1);
    do_wr(1'b0, 2'b00);
    #1 chk("R11 flag sticky", bresp_err, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule